// File: doc/BRIEF.md
# Command Block Receiver with CRC-16 Framing

This block sits between a single-wire bit decoder and a command execution engine. Once the host has signalled that a command follows, the decoder pulses `blk_start` and then delivers the block one byte at a time. The first byte is a length byte that counts the whole block, including itself and the two check bytes. The block then carries a packet made of an opcode, a one-byte parameter, a two-byte parameter and optional data. A CRC-16 closes the block.

The receiver works out where the block ends from the length byte. It runs the CRC over the length and packet bytes and checks the length against the fixed size that belongs to each opcode. It also checks the parameter fields that must hold fixed values. A good block raises a one-cycle `cmd_valid` strobe with the decoded fields, and its data bytes can be read from a small buffer. A bad block raises `err_valid` and sends a four-byte error reply on its own. The execution engine can also send any reply of its own through the same framer, which adds the length byte and the CRC.

Top module: `cmd_block_rx`

## Requirements
- R1: A length byte below 4 or above 39 raises `err_valid` in the cycle after that byte. The receiver then ignores the rest of the block.
- R2: The CRC-16 uses polynomial 0x8005 and starts at zero. It covers the length and packet bytes, and each byte enters least significant bit first. The received CRC arrives low byte first, then high byte. A mismatch raises `err_valid`.
- R3: Only these opcodes are legal, each with a fixed total block length: 0x08 needs 39, 0x02 needs 7, 0x04 needs 7, 0x01 needs 7, 0x20 needs 23 and 0x10 needs 39. Any other opcode, or a length that does not match the opcode, raises `err_valid`.
- R4: The fixed fields are checked as follows. For opcode 0x08, Param1 may have only bit 6 set and Param2 must be zero. For opcode 0x02, Param1 must be 0, 1 or 3. For opcode 0x20, Param1 must be zero. For opcode 0x04, Param2 must be 0x0000 or 0x8000. Any violation raises `err_valid`.
- R5: A correct block raises `cmd_valid` for one cycle, in the cycle after its last byte. At the same time `cmd_opcode` shows byte 1 and `cmd_param1` shows byte 2. `cmd_param2` shows byte 3 as its low half and byte 4 as its high half.
- R6: Block bytes from position 5 onward are stored in order. Data byte k appears on `data_byte` one cycle after `data_addr` is set to k.
- R7: In the cycle after `err_valid`, `tx_valid` starts an automatic reply of four consecutive bytes. The bytes are 0x04, then 0xFF, then the CRC of those two bytes, low byte first.
- R8: When `rsp_start` is pulsed with `rsp_len` equal to L, the next cycle sends L+3 on `tx_byte`. Each `pay_valid` byte is then sent one cycle later. After the L-th payload byte, the CRC low byte and the CRC high byte follow in the next two cycles.
- R9: A `blk_start` pulse throws away any partly received block. Bytes that arrive after a block has been decided do nothing until the next `blk_start`.
- R10: Each block gives exactly one `cmd_valid` or exactly one `err_valid`, never both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| blk_start | input | 1 | Marks the start of a new command block |
| in_valid | input | 1 | Incoming byte strobe |
| in_byte | input | 8 | Incoming byte |
| cmd_valid | output | 1 | One-cycle strobe for a correctly received command |
| cmd_opcode | output | 8 | Decoded opcode |
| cmd_param1 | output | 8 | Decoded one-byte parameter |
| cmd_param2 | output | 16 | Decoded two-byte parameter |
| data_addr | input | 5 | Read address into the data buffer |
| data_byte | output | 8 | Registered data buffer read value |
| err_valid | output | 1 | One-cycle strobe for a rejected block |
| rsp_start | input | 1 | Starts a reply from the execution engine |
| rsp_len | input | 6 | Payload length of that reply, from 1 to 36 |
| pay_valid | input | 1 | Reply payload byte strobe |
| pay_byte | input | 8 | Reply payload byte |
| tx_valid | output | 1 | Outgoing byte strobe |
| tx_byte | output | 8 | Outgoing reply byte |

## Verification
The assertions rely on a few input rules. `blk_start` never arrives in the same cycle as a byte. `rsp_len` stays between 1 and 36. `rsp_start` is pulsed only while the framer is idle and no parse error is pending. The bench keeps to these rules. It leaves idle cycles after every block so that the automatic error reply finishes before the next reply begins. It builds random commands only from the legal opcodes with legal field values. Faults are added on purpose and only by directed cases: bad lengths, wrong opcodes and single-bit flips in bytes after the length byte.

// File: rtl/cbr_pkg.sv
package cbr_pkg;
  localparam int MIN_BLK = 4;
  localparam int MAX_BLK = 39;
  localparam int HDR_LEN = 5;
  localparam int DATA_DEPTH = MAX_BLK - HDR_LEN - 2;
  localparam int DAW = $clog2(DATA_DEPTH);
  localparam logic [15:0] CRC_POLY = 16'h8005;
  localparam logic [7:0] ERR_CODE = 8'hFF;

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (b[i] ^ r[15]) r = (r << 1) ^ CRC_POLY;
      else r = r << 1;
    end
    return r;
  endfunction

  function automatic logic [7:0] size_of(input logic [7:0] op);
    case (op)
      8'h08, 8'h10: return 8'd39;
      8'h02, 8'h04, 8'h01: return 8'd7;
      8'h20: return 8'd23;
      default: return 8'd0;
    endcase
  endfunction

  function automatic logic fields_ok(input logic [7:0] op, input logic [7:0] p1,
                                     input logic [15:0] p2);
    case (op)
      8'h08: return ((p1 & 8'hBF) == 8'h00) && (p2 == 16'h0000);
      8'h02: return (p1 == 8'h00) || (p1 == 8'h01) || (p1 == 8'h03);
      8'h20: return p1 == 8'h00;
      8'h04: return (p2 == 16'h0000) || (p2 == 16'h8000);
      default: return 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/cbr_frame_rx.sv
module cbr_frame_rx
  import cbr_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            blk_start,
  input  logic            in_valid,
  input  logic [7:0]      in_byte,
  output logic            cmd_valid,
  output logic [7:0]      cmd_opcode,
  output logic [7:0]      cmd_param1,
  output logic [15:0]     cmd_param2,
  input  logic [DAW-1:0]  data_addr,
  output logic [7:0]      data_byte,
  output logic            err_valid
);
  logic        busy_q;
  logic [7:0]  idx_q, cnt_q, op_q, p1_q, p2l_q, p2h_q, crcl_q;
  logic [15:0] crc_q;
  logic [7:0]  mem [DATA_DEPTH];
  logic        take, wr_en, blk_ok;
  logic [DAW-1:0] wr_addr;

  assign take    = busy_q && in_valid;
  assign wr_en   = take && (idx_q >= 8'(HDR_LEN)) && (idx_q < cnt_q - 8'd2);
  assign wr_addr = DAW'(idx_q - 8'(HDR_LEN));
  assign blk_ok  = ({in_byte, crcl_q} == crc_q) && (size_of(op_q) == cnt_q)
                   && fields_ok(op_q, p1_q, {p2h_q, p2l_q});

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= in_byte;
    data_byte <= mem[data_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0; idx_q <= '0; cnt_q <= '0; crc_q <= '0;
      op_q <= '0; p1_q <= '0; p2l_q <= '0; p2h_q <= '0; crcl_q <= '0;
      cmd_valid <= 1'b0; err_valid <= 1'b0;
    end else begin
      cmd_valid <= 1'b0;
      err_valid <= 1'b0;
      if (blk_start) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
        crc_q  <= '0;
      end else if (take) begin
        idx_q <= idx_q + 8'd1;
        if (idx_q == 8'd0) begin
          cnt_q <= in_byte;
          crc_q <= crc_step(16'h0000, in_byte);
          if (in_byte < 8'(MIN_BLK) || in_byte > 8'(MAX_BLK)) begin
            busy_q    <= 1'b0;
            err_valid <= 1'b1;
          end
        end else if (idx_q < cnt_q - 8'd2) begin
          crc_q <= crc_step(crc_q, in_byte);
          case (idx_q)
            8'd1: op_q  <= in_byte;
            8'd2: p1_q  <= in_byte;
            8'd3: p2l_q <= in_byte;
            8'd4: p2h_q <= in_byte;
            default: ;
          endcase
        end else if (idx_q == cnt_q - 8'd2) begin
          crcl_q <= in_byte;
        end else begin
          busy_q    <= 1'b0;
          cmd_valid <= blk_ok;
          err_valid <= !blk_ok;
        end
      end
    end
  end

  assign cmd_opcode = op_q;
  assign cmd_param1 = p1_q;
  assign cmd_param2 = {p2h_q, p2l_q};

  // R10
  one_outcome_chk: assert property (@(posedge clk) disable iff (rst)
    !(cmd_valid && err_valid));
  // R5
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> !cmd_valid);
  // R3
  known_opcode_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> (size_of(cmd_opcode) == cnt_q));
  // R1
  legal_length_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> (cnt_q >= 8'(MIN_BLK) && cnt_q <= 8'(MAX_BLK)));
endmodule

// File: rtl/cbr_rsp_tx.sv
module cbr_rsp_tx
  import cbr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       auto_err,
  input  logic       rsp_start,
  input  logic [5:0] rsp_len,
  input  logic       pay_valid,
  input  logic [7:0] pay_byte,
  output logic       tx_valid,
  output logic [7:0] tx_byte
);
  typedef enum logic [1:0] {S_IDLE, S_PAY, S_CRCL, S_CRCH} tx_st_e;
  tx_st_e      st_q;
  logic [15:0] crc_q;
  logic [5:0]  rem_q;
  logic        auto_q, feed;
  logic [7:0]  feed_byte, cnt_byte;

  assign feed      = auto_q || pay_valid;
  assign feed_byte = auto_q ? ERR_CODE : pay_byte;
  assign cnt_byte  = auto_err ? 8'd4 : 8'(rsp_len) + 8'd3;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= S_IDLE; crc_q <= '0; rem_q <= '0; auto_q <= 1'b0;
      tx_valid <= 1'b0; tx_byte <= '0;
    end else begin
      tx_valid <= 1'b0;
      case (st_q)
        S_IDLE: if (auto_err || rsp_start) begin
          tx_valid <= 1'b1;
          tx_byte  <= cnt_byte;
          crc_q    <= crc_step(16'h0000, cnt_byte);
          rem_q    <= auto_err ? 6'd1 : rsp_len;
          auto_q   <= auto_err;
          st_q     <= S_PAY;
        end
        S_PAY: if (feed) begin
          tx_valid <= 1'b1;
          tx_byte  <= feed_byte;
          crc_q    <= crc_step(crc_q, feed_byte);
          rem_q    <= rem_q - 6'd1;
          if (rem_q == 6'd1) begin
            st_q   <= S_CRCL;
            auto_q <= 1'b0;
          end
        end
        S_CRCL: begin
          tx_valid <= 1'b1;
          tx_byte  <= crc_q[7:0];
          st_q     <= S_CRCH;
        end
        default: begin
          tx_valid <= 1'b1;
          tx_byte  <= crc_q[15:8];
          st_q     <= S_IDLE;
        end
      endcase
    end
  end

  // R8
  reply_length_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_IDLE && (auto_err || rsp_start)) |=>
      (tx_valid && tx_byte >= 8'(MIN_BLK) && tx_byte <= 8'(MAX_BLK)));
  // R7
  auto_reply_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_IDLE && auto_err) |=> ##1 (tx_valid && tx_byte == ERR_CODE));
endmodule

// File: rtl/cmd_block_rx.sv
module cmd_block_rx
  import cbr_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            blk_start,
  input  logic            in_valid,
  input  logic [7:0]      in_byte,
  output logic            cmd_valid,
  output logic [7:0]      cmd_opcode,
  output logic [7:0]      cmd_param1,
  output logic [15:0]     cmd_param2,
  input  logic [DAW-1:0]  data_addr,
  output logic [7:0]      data_byte,
  output logic            err_valid,
  input  logic            rsp_start,
  input  logic [5:0]      rsp_len,
  input  logic            pay_valid,
  input  logic [7:0]      pay_byte,
  output logic            tx_valid,
  output logic [7:0]      tx_byte
);
  cbr_frame_rx u_rx (
    .clk, .rst, .blk_start, .in_valid, .in_byte,
    .cmd_valid, .cmd_opcode, .cmd_param1, .cmd_param2,
    .data_addr, .data_byte, .err_valid
  );

  cbr_rsp_tx u_tx (
    .clk, .rst, .auto_err(err_valid), .rsp_start, .rsp_len,
    .pay_valid, .pay_byte, .tx_valid, .tx_byte
  );
endmodule

// File: tb/cmd_block_rx_test.sv
module cmd_block_rx_test;
  logic clk = 0, rst = 1, blk_start = 0, in_valid = 0, rsp_start = 0, pay_valid = 0;
  logic [7:0] in_byte = 0, pay_byte = 0, cmd_opcode, cmd_param1, data_byte, tx_byte;
  logic [15:0] cmd_param2;
  logic [4:0] data_addr = 0;
  logic [5:0] rsp_len = 0;
  logic cmd_valid, err_valid, tx_valid;
  int n_run = 0, n_fail = 0, n_cmd = 0, n_err = 0, txn = 0;
  logic [7:0] blk [64];
  logic [7:0] txb [64];

  always #5 clk = ~clk;

  cmd_block_rx uut (.*);

  always @(negedge clk) begin
    if (cmd_valid) n_cmd++;
    if (err_valid) n_err++;
    if (tx_valid && txn < 64) begin txb[txn] = tx_byte; txn++; end
  end

  function automatic logic [15:0] ref_crc(input int n);
    logic [15:0] r = 0;
    for (int k = 0; k < n; k++)
      for (int i = 0; i < 8; i++)
        r = (blk[k][i] ^ r[15]) ? ((r << 1) ^ 16'h8005) : (r << 1);
    return r;
  endfunction

  function automatic int ref_size(input logic [7:0] op);
    case (op)
      8'h08, 8'h10: return 39;
      8'h20: return 23;
      8'h02, 8'h04, 8'h01: return 7;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin n_fail++; $display("FAIL %s actual=%0h expected=%0h", req, act, exp); end
  endtask

  task automatic seal(input int n);
    logic [15:0] c;
    blk[0] = 8'(n);
    c = ref_crc(n - 2);
    blk[n-2] = c[7:0];
    blk[n-1] = c[15:8];
  endtask

  task automatic make(input logic [7:0] op, input logic [7:0] p1, input logic [15:0] p2, input int n);
    blk[1] = op; blk[2] = p1; blk[3] = p2[7:0]; blk[4] = p2[15:8];
    for (int i = 5; i < n - 2; i++) blk[i] = 8'($urandom);
    seal(n);
  endtask

  task automatic start_blk();
    @(negedge clk); blk_start = 1;
    @(negedge clk); blk_start = 0;
    n_cmd = 0; n_err = 0; txn = 0;
  endtask

  task automatic send(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); in_valid = 1; in_byte = blk[i];
    end
    @(negedge clk); in_valid = 0;
  endtask

  task automatic expect_err_reply(input string req);
    logic [15:0] c;
    repeat (6) @(negedge clk);
    blk[0] = 8'h04; blk[1] = 8'hFF; c = ref_crc(2);
    chk(txn == 4 && txb[0] == 8'h04 && txb[1] == 8'hFF && txb[2] == c[7:0] && txb[3] == c[15:8],
        req, {txb[0], txb[1], txb[2], txb[3]}, {8'h04, 8'hFF, c[7:0], c[15:8]});
  endtask

  task automatic good_blk(input logic [7:0] op, input logic [7:0] p1, input logic [15:0] p2);
    int n = ref_size(op);
    make(op, p1, p2, n);
    start_blk(); send(n);
    // R5: strobe visible in the cycle after the last byte
    chk(cmd_valid === 1'b1 && cmd_opcode == op && cmd_param1 == p1 && cmd_param2 == p2,
        "R5", {cmd_valid, cmd_opcode, cmd_param1, cmd_param2}, {1'b1, op, p1, p2});
    repeat (3) @(negedge clk);
    chk(n_cmd == 1 && n_err == 0, "R10", n_cmd * 16 + n_err, 16);
  endtask

  task automatic bad_blk(input int n, input string req);
    start_blk(); send(n);
    repeat (2) @(negedge clk);
    chk(n_err == 1 && n_cmd == 0, req, n_err * 16 + n_cmd, 16);
    expect_err_reply("R7");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] c;
    logic [7:0] ops [6] = '{8'h08, 8'h02, 8'h04, 8'h01, 8'h20, 8'h10};
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(cmd_valid == 0 && err_valid == 0 && tx_valid == 0, "R5 reset", {cmd_valid, err_valid, tx_valid}, 0);

    good_blk(8'h02, 8'h03, 16'h1234);
    good_blk(8'h08, 8'h40, 16'h0000);
    // R6: data readback of the last MAC block
    for (int i = 0; i < 32; i++) begin
      @(negedge clk); data_addr = 5'(i);
      @(negedge clk);
      chk(data_byte == blk[i+5], "R6", data_byte, blk[i+5]);
    end
    good_blk(8'h04, 8'd87, 16'h8000);
    good_blk(8'h20, 8'h00, 16'hBEEF);

    // R1: too short and too long, followed by junk that must be ignored (R9)
    for (int t = 0; t < 2; t++) begin
      start_blk();
      blk[0] = t ? 8'd40 : 8'd3;
      for (int i = 1; i < 8; i++) blk[i] = 8'h00;
      send(1);
      chk(err_valid === 1'b1, "R1", err_valid, 1);
      send(8);
      repeat (2) @(negedge clk);
      chk(n_err == 1 && n_cmd == 0, "R9", n_err, 1);
      expect_err_reply("R7");
    end

    // R2: corrupted CRC high byte
    make(8'h01, 8'h05, 16'h0000, 7); blk[6] ^= 8'h01;
    bad_blk(7, "R2");
    // R3: unknown opcode and mismatched length
    make(8'h03, 8'h00, 16'h0000, 7); bad_blk(7, "R3");
    make(8'h08, 8'h00, 16'h0000, 23); bad_blk(23, "R3");
    // R4: fixed-field violations
    make(8'h08, 8'h41, 16'h0000, 39); bad_blk(39, "R4");
    make(8'h02, 8'h02, 16'h0000, 7); bad_blk(7, "R4");
    make(8'h20, 8'h01, 16'h0000, 23); bad_blk(23, "R4");
    make(8'h04, 8'h00, 16'h0001, 7); bad_blk(7, "R4");

    // R9: restart discards a partial block
    make(8'h10, 8'h00, 16'h0000, 39);
    start_blk(); send(10);
    good_blk(8'h01, 8'h0C, 16'h0000);

    // R8: engine reply of 3 payload bytes
    txn = 0;
    @(negedge clk); rsp_start = 1; rsp_len = 6'd3;
    @(negedge clk); rsp_start = 0;
    chk(tx_valid === 1'b1 && tx_byte == 8'd6, "R8", tx_byte, 6);
    for (int i = 0; i < 3; i++) begin
      pay_valid = 1; pay_byte = 8'h0F + 8'(i);
      @(negedge clk);
    end
    pay_valid = 0;
    repeat (4) @(negedge clk);
    blk[0] = 8'd6; blk[1] = 8'h0F; blk[2] = 8'h10; blk[3] = 8'h11; c = ref_crc(4);
    chk(txn == 6 && txb[4] == c[7:0] && txb[5] == c[15:8], "R8", {txb[4], txb[5]}, c);

    // random mix of legal commands and single-bit faults
    for (int it = 0; it < 40; it++) begin
      logic [7:0] op, p1; logic [15:0] p2; int n, pos;
      op = ops[$urandom_range(0, 5)];
      p1 = 8'($urandom); p2 = 16'($urandom);
      case (op)
        8'h08: begin p1 = $urandom_range(0, 1) ? 8'h40 : 8'h00; p2 = 0; end
        8'h02: p1 = ($urandom_range(0, 2) == 2) ? 8'h03 : 8'($urandom_range(0, 1));
        8'h04: begin p1 = 8'($urandom_range(0, 87)); p2 = $urandom_range(0, 1) ? 16'h8000 : 16'h0; end
        8'h20: p1 = 0;
        default: ;
      endcase
      n = ref_size(op);
      if ($urandom_range(0, 3) == 0) begin
        make(op, p1, p2, n);
        pos = $urandom_range(1, n - 1);
        blk[pos] ^= 8'(1 << $urandom_range(0, 7));
        bad_blk(n, "R2");
      end else good_blk(op, p1, p2);
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule